// File: doc/BRIEF.md
# PWM Trigger Postscaler With Start-up Holdoff

This block sits next to a PWM time base. It turns raw trigger-compare events into registered trigger pulses, for example to start an ADC conversion. It takes a primary and a secondary compare event, a PWM cycle-start strobe and an enable. It applies three settings. The first is a holdoff counted in PWM cycles after enable. The second is an every-Nth-event postscaler. The third is a select that either merges the two event paths or keeps them apart.

After enable, the block counts cycle-start strobes until it reaches the holdoff value. Events that arrive before then are dropped. From that point each path runs its own event counter. A path fires on every (D+1)th accepted event. When merging is selected, both gated paths drive the primary output. Only the primary path raises the interrupt request.

Top module: `pwm_trig_postscaler`

## Requirements
- R1: With divider field `div_i` = D (4 bits, 0..15), each path emits one pulse on every (D+1)th accepted event on that path. D=0 passes every event.
- R2: With start field `start_i` = S (6 bits, 0..63), an event is accepted only after S cycle-start strobes have been seen while enabled. An event in the same clock as the S-th strobe is still dropped. Dropped events do not advance the postscaler.
- R3: With `dual_i`=1, `pri_trig_o` is the OR of the two gated paths. A primary and a secondary fire in the same clock give a single one-clock pulse, and `sec_trig_o` stays 0.
- R4: With `dual_i`=0, the gated primary path drives `pri_trig_o` and the gated secondary path drives `sec_trig_o`, each on its own.
- R5: `irq_o` pulses exactly when the gated primary path fires. A secondary fire never raises it, in either mode.
- R6: While `rst_ni` is low, all outputs are 0. With all settings at zero, every event passes, no holdoff applies and the outputs stay separate.
- R7: While `en_i` is low, the holdoff and event counters clear and no output fires. After re-enable, the first pulse falls on the (D+1)th accepted event.
- R8: A new `div_i` value takes effect only when a path's event counter next wraps, or while the block is disabled.
- R9: Every output is registered. It is high for the one clock that follows the edge at which the firing event was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Block enable; low clears counters |
| cyc_start_i | input | 1 | PWM cycle-start strobe |
| pri_evt_i | input | 1 | Primary trigger-compare event |
| sec_evt_i | input | 1 | Secondary trigger-compare event |
| div_i | input | 4 | Postscaler value D (every D+1 events) |
| start_i | input | 6 | Holdoff in PWM cycles |
| dual_i | input | 1 | 1 = merge paths onto primary output |
| pri_trig_o | output | 1 | Primary or merged trigger pulse |
| sec_trig_o | output | 1 | Secondary trigger pulse |
| irq_o | output | 1 | Trigger interrupt request, primary only |

## Verification
Every output is due exactly one clock after the edge that samples the firing event. The bench drives inputs at the falling edge and updates its arithmetic model for that cycle. It then waits for one rising edge and compares all three outputs at the next falling edge. It sweeps every divider value under several holdoff values in both modes. It also covers disable and re-enable, a change of divider in mid-count, the largest holdoff, and primary and secondary events arriving in the same clock. Each clock of each run is checked, so a pulse that comes early, late or extra is reported in that same cycle.

// File: rtl/pts_pkg.sv
package pts_pkg;
  localparam int unsigned DIV_W   = 4;
  localparam int unsigned START_W = 6;
  localparam int unsigned N_PATH  = 2;
  localparam int unsigned PRI     = 0;
  localparam int unsigned SEC     = 1;
endpackage

// File: rtl/pts_holdoff.sv
module pts_holdoff #(
  parameter int unsigned START_W = pts_pkg::START_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               cyc_start_i,
  input  logic [START_W-1:0] start_i,
  output logic               ready_o
);
  logic [START_W-1:0] cnt_q;

  assign ready_o = en_i && (cnt_q >= start_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!en_i)                    cnt_q <= '0;
    else if (cyc_start_i && !ready_o)  cnt_q <= cnt_q + 1'b1;
  end

  p_hold_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
  p_hold_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !cyc_start_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/pts_divider.sv
module pts_divider #(
  parameter int unsigned DIV_W = pts_pkg::DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ready_i,
  input  logic             evt_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             fire_o
);
  logic [DIV_W-1:0] cnt_q, lim_q;
  logic             take;

  assign take   = ready_i && evt_i;
  assign fire_o = take && (cnt_q == lim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
      lim_q <= div_i;
    end else if (take) begin
      if (cnt_q == lim_q) begin
        cnt_q <= '0;
        lim_q <= div_i;   // new divider applies at wrap
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_q);
  p_lim_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !fire_o) |=> $stable(lim_q));
endmodule

// File: rtl/pwm_trig_postscaler.sv
module pwm_trig_postscaler
  import pts_pkg::*;
#(
  parameter int unsigned DW = DIV_W,
  parameter int unsigned SW = START_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          cyc_start_i,
  input  logic          pri_evt_i,
  input  logic          sec_evt_i,
  input  logic [DW-1:0] div_i,
  input  logic [SW-1:0] start_i,
  input  logic          dual_i,
  output logic          pri_trig_o,
  output logic          sec_trig_o,
  output logic          irq_o
);
  logic              ready;
  logic [N_PATH-1:0] evt, fire;

  assign evt = {sec_evt_i, pri_evt_i};

  pts_holdoff #(.START_W(SW)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .cyc_start_i(cyc_start_i), .start_i(start_i), .ready_o(ready)
  );

  for (genvar g = 0; g < N_PATH; g++) begin : g_path
    pts_divider #(.DIV_W(DW)) u_div (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .ready_i(ready),
      .evt_i(evt[g]), .div_i(div_i), .fire_o(fire[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_trig_o <= 1'b0;
      sec_trig_o <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      pri_trig_o <= fire[PRI] | (dual_i & fire[SEC]);
      sec_trig_o <= ~dual_i & fire[SEC];
      irq_o      <= fire[PRI];
    end
  end

  p_hold_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |=> (!pri_trig_o && !sec_trig_o && !irq_o));
  p_dual_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dual_i |=> !sec_trig_o);
  p_irq_pri_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pri_trig_o);
  p_sep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dual_i && !pri_evt_i) |=> (!pri_trig_o && !irq_o));
endmodule

// File: tb/sim_pwm_trig_postscaler.sv
module sim_pwm_trig_postscaler;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic en = 0, cs = 0, pe = 0, se = 0, dual = 0;
  logic [3:0] div = 0;
  logic [5:0] start = 0;
  logic pri_o, sec_o, irq_o;
  int errors = 0, checks = 0;
  bit done = 0;

  // model state
  int hc = 0, pc = 0, sc = 0, pl = 0, sl = 0;

  always #2.5 clk = ~clk;

  pwm_trig_postscaler u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .cyc_start_i(cs),
    .pri_evt_i(pe), .sec_evt_i(se), .div_i(div), .start_i(start),
    .dual_i(dual), .pri_trig_o(pri_o), .sec_trig_o(sec_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // drive at negedge, model the cycle, compare one clock later (R9)
  task automatic step(input logic e, input logic c, input logic p, input logic s, input string tag);
    bit rdy, pf, sf, ep, es;
    en = e; cs = c; pe = p; se = s;
    if (!e) begin
      hc = 0; pc = 0; sc = 0; pl = div; sl = div; pf = 0; sf = 0;
    end else begin
      rdy = (hc >= start);
      pf = rdy && p && (pc == pl);
      sf = rdy && s && (sc == sl);
      if (rdy && p) begin if (pc == pl) begin pc = 0; pl = div; end else pc++; end
      if (rdy && s) begin if (sc == sl) begin sc = 0; sl = div; end else sc++; end
      if (c && !rdy) hc++;
    end
    ep = dual ? (pf | sf) : pf;
    es = dual ? 1'b0 : sf;
    @(posedge clk); @(negedge clk);
    chk(tag, dual ? "R3 pri_trig" : "R4 pri_trig", pri_o, ep);
    chk(tag, dual ? "R3 sec_trig" : "R4 sec_trig", sec_o, es);
    chk(tag, "R5 irq", irq_o, pf);
  endtask

  // one PWM cycle of 4 clocks; same=1 puts both events in one clock
  task automatic pwm_cyc(input bit same, input string tag);
    step(1, 1, 0, 0, tag);
    step(1, 0, 1, same, tag);
    step(1, 0, 0, !same, tag);
    step(1, 0, 0, 0, tag);
  endtask

  initial begin : watchdog
    #(5ns * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R6", "reset pri", pri_o, 1'b0);
    chk("R6", "reset sec", sec_o, 1'b0);
    chk("R6", "reset irq", irq_o, 1'b0);
    rst_ni = 1'b1;
    // R6: zero settings pass every event, separate outputs
    step(0, 0, 0, 0, "R6");
    for (int k = 0; k < 4; k++) pwm_cyc(0, "R6");
    // R1 R2 R3 R4 sweep
    for (int m = 0; m < 2; m++)
      for (int d = 0; d < 16; d++)
        for (int si = 0; si < 3; si++) begin
          dual = m[0]; div = d[3:0];
          start = (si == 0) ? 6'd0 : (si == 1) ? 6'd2 : 6'd5;
          step(0, 0, 0, 0, "R7");
          for (int k = 0; k < 12; k++) pwm_cyc(m[0] && (k % 3 == 0), "R1");
        end
    // R2: largest holdoff
    dual = 0; div = 1; start = 6'd63;
    step(0, 0, 0, 0, "R2");
    for (int k = 0; k < 68; k++) pwm_cyc(0, "R2");
    // R8: divider change mid-count, applied at wrap
    start = 0; div = 4;
    step(0, 0, 0, 0, "R8");
    pwm_cyc(0, "R8"); pwm_cyc(0, "R8");
    div = 1;
    for (int k = 0; k < 10; k++) pwm_cyc(0, "R8");
    // R7: disable mid-count, re-enable restarts the count
    div = 2; start = 1;
    step(0, 0, 0, 0, "R7");
    pwm_cyc(0, "R7"); pwm_cyc(0, "R7");
    step(0, 0, 1, 1, "R7");
    for (int k = 0; k < 8; k++) pwm_cyc(0, "R7");
    // R3 R9: simultaneous events back to back in dual mode
    dual = 1; div = 0; start = 0;
    step(0, 0, 0, 0, "R9");
    for (int k = 0; k < 4; k++) step(1, 0, 1, 1, "R9");
    step(1, 0, 0, 0, "R9");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule